// File: doc/BRIEF.md
# Least-Recently-Used Tag Match Array

This block holds a small set of tags and answers, in one operation, whether a lookup key equals any valid stored tag. All entries are compared at the same time. On a hit it returns the matching entry's number and a few user-defined state bits kept with that entry. On a miss it returns the number of the entry used least recently, which the caller can overwrite. The block stores no payload. The entry number is meant to index a data table kept elsewhere.

Each lookup is answered one clock later by a registered result. The result holds a hit flag, an entry number and the state bits. Software fills an entry through a tag write port, which sets the tag, the state and the valid bit together. A second, narrower port changes only an entry's state bits. A clear input empties the whole array.

Recency is a full ordering of the entries. A hit moves the matching entry to the most-recent end of that ordering, and so does a tag write.

Top module: `lru_cam`

## Requirements
- R1: After reset or clear_i, every entry is invalid and the recency order, from least to most recent, is entry 0, 1, …, 15. A lookup issued next therefore misses and reports entry 0.
- R2: res_valid_o is 1 in the cycle after a cycle with lk_valid_i high, and 0 in the cycle after a cycle with lk_valid_i low. When res_valid_o is 0, the other result outputs keep their previous values.
- R3: When a valid entry's tag equals lk_tag_i, the result shows res_hit_o=1, res_idx_o set to that entry's number, and res_state_o set to that entry's 4 state bits.
- R4: On a miss, the result shows res_hit_o=0, res_state_o=0 and res_idx_o set to the least recently used entry as it stood in the lookup cycle.
- R5: An invalid entry never matches, whatever its stored tag, including the all-zero tag left by a clear.
- R6: When several valid entries hold the key, the lowest-numbered of them is reported.
- R7: A hit makes the matching entry the most recent. A miss leaves the recency order unchanged.
- R8: A tag write (wr_valid_i) stores wr_tag_i and wr_state_i at wr_idx_i, marks that entry valid and makes it the most recent.
- R9: A state-only write (st_valid_i) replaces only the state bits of st_idx_i. The tag, the valid bit and the recency order are untouched.
- R10: A lookup sees the contents as they were before the writes of its own cycle. When a hit and a tag write fall in the same cycle, the hit's recency update is applied first and the written entry ends as the most recent.
- R11: clear_i overrides every write and recency update of its cycle. A lookup issued in that cycle is still answered from the contents before the clear.
- R12: When a tag write and a state-only write target the same entry in one cycle, the tag write's state bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Empties all entries and restores the initial recency order |
| lk_valid_i | input | 1 | Lookup request |
| lk_tag_i | input | 32 | Lookup key |
| wr_valid_i | input | 1 | Tag write request |
| wr_idx_i | input | 4 | Entry to write |
| wr_tag_i | input | 32 | Tag to store |
| wr_state_i | input | 4 | State bits stored with the tag |
| st_valid_i | input | 1 | State-only write request |
| st_idx_i | input | 4 | Entry whose state bits change |
| st_state_i | input | 4 | New state bits |
| res_valid_o | output | 1 | Result present (one cycle after lookup) |
| res_hit_o | output | 1 | 1 on hit, 0 on miss |
| res_idx_o | output | 4 | Matching entry on hit, least recently used entry on miss |
| res_state_o | output | 4 | State bits of the hit entry, 0 on miss |

## Verification
The difficult overlap is a lookup and a tag write in the same cycle. Both change the recency order, and the write may also change the very entry being matched. The bench drives such cycles on purpose: a write to the entry that hits, a write to a different entry, and each of these together with a clear or a state-only write. The bench also generates random traffic over a small pool of tags, so that these overlaps and duplicate tags occur often. On every clock, a behavioural model keeps the recency order as a queue and predicts the registered result. The order of the next misses then shows whether the two recency updates were applied in the required order.

// File: rtl/lru_cam_pkg.sv
package lru_cam_pkg;
    localparam int CAM_ENTRIES = 16;
    localparam int CAM_TAG_W   = 32;
    localparam int CAM_STATE_W = 4;
endpackage

// File: rtl/lru_cam_store.sv
module lru_cam_store #(
    parameter int N  = 16,
    parameter int TW = 32,
    parameter int SW = 4,
    parameter int IW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  wr_en_i,
    input  logic [IW-1:0]         wr_idx_i,
    input  logic [TW-1:0]         wr_tag_i,
    input  logic [SW-1:0]         wr_state_i,
    input  logic                  st_en_i,
    input  logic [IW-1:0]         st_idx_i,
    input  logic [SW-1:0]         st_state_i,
    output logic [N-1:0]          valid_o,
    output logic [N-1:0][TW-1:0]  tag_o,
    output logic [N-1:0][SW-1:0]  state_o
);
    typedef struct packed {
        logic [N-1:0]          valid;
        logic [N-1:0][TW-1:0]  tag;
        logic [N-1:0][SW-1:0]  state;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            // state-only write first; a tag write to the same entry overrides it (R12)
            if (st_en_i)
                st_d.state[st_idx_i] = st_state_i;
            if (wr_en_i) begin
                st_d.valid[wr_idx_i] = 1'b1;
                st_d.tag[wr_idx_i]   = wr_tag_i;
                st_d.state[wr_idx_i] = wr_state_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign tag_o   = st_q.tag;
    assign state_o = st_q.state;

    a_r8_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !clear_i |=> valid_o[$past(wr_idx_i)] && tag_o[$past(wr_idx_i)] == $past(wr_tag_i));

    a_r9_state_write_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
        st_en_i && !wr_en_i && !clear_i |=> $stable(tag_o) && $stable(valid_o));

    a_r12_tag_write_state_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && st_en_i && !clear_i && wr_idx_i == st_idx_i
        |=> state_o[$past(wr_idx_i)] == $past(wr_state_i));

    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> valid_o == '0);
endmodule

// File: rtl/lru_cam_match.sv
module lru_cam_match #(
    parameter int N  = 16,
    parameter int TW = 32,
    parameter int IW = 4
) (
    input  logic [N-1:0]          valid_i,
    input  logic [N-1:0][TW-1:0]  tag_i,
    input  logic [TW-1:0]         key_i,
    output logic                  hit_o,
    output logic [IW-1:0]         idx_o
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (tag_i[g] == key_i);
    end

    // lowest-numbered match wins: scan from the top so the lowest index is written last
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IW'(i);
        end
    end

    assign hit_o = |eq;
endmodule

// File: rtl/lru_cam_order.sv
module lru_cam_order #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          hit_en_i,
    input  logic [IW-1:0] hit_idx_i,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    output logic [IW-1:0] lru_o
);
    typedef logic [N-1:0][IW-1:0] ord_t;

    ord_t ord_d, ord_q;

    function automatic ord_t initial_order();
        ord_t r;
        for (int i = 0; i < N; i++) r[i] = IW'(i);
        return r;
    endfunction

    // remove entry e from its slot, close the gap, append it at the most-recent end
    function automatic ord_t touch(ord_t o, logic [IW-1:0] e);
        ord_t r;
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N - 1; i++) begin
            if (o[i] == e) seen = 1'b1;
            r[i] = seen ? o[i+1] : o[i];
        end
        r[N-1] = e;
        return r;
    endfunction

    always_comb begin
        ord_d = ord_q;
        if (clear_i) begin
            ord_d = initial_order();
        end else begin
            if (hit_en_i) ord_d = touch(ord_d, hit_idx_i);
            if (wr_en_i)  ord_d = touch(ord_d, wr_idx_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ord_q <= initial_order();
        else        ord_q <= ord_d;
    end

    assign lru_o = ord_q[0];

    logic [N-1:0] present;
    always_comb begin
        present = '0;
        for (int i = 0; i < N; i++) present[ord_q[i]] = 1'b1;
    end

    a_r7_order_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        present == {N{1'b1}});

    a_r1_clear_restores_order: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ord_q[0] == '0 && ord_q[N-1] == IW'(N-1));

    a_r10_write_ends_most_recent: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !clear_i |=> ord_q[N-1] == $past(wr_idx_i));

    a_r7_hit_becomes_most_recent: assert property (@(posedge clk) disable iff (!rst_n)
        hit_en_i && !wr_en_i && !clear_i |=> ord_q[N-1] == $past(hit_idx_i));

    a_r7_idle_order_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i && !hit_en_i && !wr_en_i |=> $stable(ord_q));
endmodule

// File: rtl/lru_cam.sv
module lru_cam
    import lru_cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES,
    parameter int TAG_W   = CAM_TAG_W,
    parameter int STATE_W = CAM_STATE_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               lk_valid_i,
    input  logic [TAG_W-1:0]   lk_tag_i,
    input  logic               wr_valid_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [TAG_W-1:0]   wr_tag_i,
    input  logic [STATE_W-1:0] wr_state_i,
    input  logic               st_valid_i,
    input  logic [IDX_W-1:0]   st_idx_i,
    input  logic [STATE_W-1:0] st_state_i,
    output logic               res_valid_o,
    output logic               res_hit_o,
    output logic [IDX_W-1:0]   res_idx_o,
    output logic [STATE_W-1:0] res_state_o
);
    typedef struct packed {
        logic               valid;
        logic               hit;
        logic [IDX_W-1:0]   idx;
        logic [STATE_W-1:0] state;
    } res_t;

    logic [ENTRIES-1:0]              ent_valid;
    logic [ENTRIES-1:0][TAG_W-1:0]   ent_tag;
    logic [ENTRIES-1:0][STATE_W-1:0] ent_state;
    logic                            m_hit;
    logic [IDX_W-1:0]                m_idx;
    logic [IDX_W-1:0]                lru_idx;
    res_t                            res_d, res_q;

    lru_cam_store #(.N(ENTRIES), .TW(TAG_W), .SW(STATE_W), .IW(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .wr_en_i    (wr_valid_i),
        .wr_idx_i   (wr_idx_i),
        .wr_tag_i   (wr_tag_i),
        .wr_state_i (wr_state_i),
        .st_en_i    (st_valid_i),
        .st_idx_i   (st_idx_i),
        .st_state_i (st_state_i),
        .valid_o    (ent_valid),
        .tag_o      (ent_tag),
        .state_o    (ent_state)
    );

    lru_cam_match #(.N(ENTRIES), .TW(TAG_W), .IW(IDX_W)) u_match (
        .valid_i (ent_valid),
        .tag_i   (ent_tag),
        .key_i   (lk_tag_i),
        .hit_o   (m_hit),
        .idx_o   (m_idx)
    );

    lru_cam_order #(.N(ENTRIES), .IW(IDX_W)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .hit_en_i  (lk_valid_i && m_hit),
        .hit_idx_i (m_idx),
        .wr_en_i   (wr_valid_i),
        .wr_idx_i  (wr_idx_i),
        .lru_o     (lru_idx)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = lk_valid_i;
        if (lk_valid_i) begin
            res_d.hit   = m_hit;
            res_d.idx   = m_hit ? m_idx : lru_idx;
            res_d.state = m_hit ? ent_state[m_idx] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid_o = res_q.valid;
    assign res_hit_o   = res_q.hit;
    assign res_idx_o   = res_q.idx;
    assign res_state_o = res_q.state;

    a_r2_result_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> res_valid_o);

    a_r2_no_result_without_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> !res_valid_o && $stable(res_idx_o) && $stable(res_hit_o));

    a_r3_hit_entry_matches: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i && m_hit |-> ent_tag[m_idx] == lk_tag_i);

    a_r5_hit_entry_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i && m_hit |-> ent_valid[m_idx]);

    a_r4_miss_reports_lru: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i && !m_hit |=> !res_hit_o && res_state_o == '0 && res_idx_o == $past(lru_idx));
endmodule

// File: tb/tb_lru_cam.sv
module tb_lru_cam;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        lk_valid_i = 1'b0;
    logic [31:0] lk_tag_i = '0;
    logic        wr_valid_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_tag_i = '0;
    logic [3:0]  wr_state_i = '0;
    logic        st_valid_i = 1'b0;
    logic [3:0]  st_idx_i = '0;
    logic [3:0]  st_state_i = '0;
    logic        res_valid_o, res_hit_o;
    logic [3:0]  res_idx_o, res_state_o;

    lru_cam dut (.*);

    always #10 clk = ~clk;

    // behavioural reference
    bit [31:0] m_tag [N];
    bit        m_val [N];
    bit [3:0]  m_st  [N];
    int        m_ord [$];
    bit        e_valid, e_hit;
    int        e_idx, e_state;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    function automatic void model_clear();
        m_ord = {};
        for (int i = 0; i < N; i++) begin
            m_tag[i] = 0; m_val[i] = 0; m_st[i] = 0; m_ord.push_back(i);
        end
    endfunction

    function automatic void model_touch(int e);
        for (int p = 0; p < m_ord.size(); p++)
            if (m_ord[p] == e) begin m_ord.delete(p); break; end
        m_ord.push_back(e);
    endfunction

    function automatic void model_step();
        int hi = -1;
        if (lk_valid_i)
            for (int i = 0; i < N; i++)
                if (hi < 0 && m_val[i] && m_tag[i] == lk_tag_i) hi = i;
        e_valid = lk_valid_i;
        if (lk_valid_i) begin
            e_hit   = (hi >= 0);
            e_idx   = (hi >= 0) ? hi : m_ord[0];
            e_state = (hi >= 0) ? int'(m_st[hi]) : 0;
        end
        if (clear_i) begin
            model_clear();
        end else begin
            if (hi >= 0) model_touch(hi);
            if (st_valid_i) m_st[st_idx_i] = st_state_i;
            if (wr_valid_i) begin
                m_tag[wr_idx_i] = wr_tag_i; m_val[wr_idx_i] = 1;
                m_st[wr_idx_i] = wr_state_i; model_touch(int'(wr_idx_i));
            end
        end
    endfunction

    task automatic compare();
        n_cmp++;
        if (res_valid_o !== e_valid ||
            (e_valid && (res_hit_o !== e_hit || int'(res_idx_o) != e_idx || int'(res_state_o) != e_state))) begin
            n_bad++;
            $display("FAIL %s t=%0t: got v=%0b h=%0b idx=%0d st=%0d, expected v=%0b h=%0b idx=%0d st=%0d",
                     cur_req, $time, res_valid_o, res_hit_o, res_idx_o, res_state_o,
                     e_valid, e_hit, e_idx, e_state);
        end
    endtask

    task automatic step(bit lk, bit [31:0] key, bit wr, int widx, bit [31:0] wtag, int wst,
                        bit st, int sidx, int sst, bit clr);
        @(negedge clk);
        compare();
        lk_valid_i = lk; lk_tag_i = key;
        wr_valid_i = wr; wr_idx_i = 4'(widx); wr_tag_i = wtag; wr_state_i = 4'(wst);
        st_valid_i = st; st_idx_i = 4'(sidx); st_state_i = 4'(sst);
        clear_i = clr;
        model_step();
    endtask

    task automatic look(bit [31:0] key);
        step(1, key, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(int idx, bit [31:0] tag, int s);
        step(0, 0, 1, idx, tag, s, 0, 0, 0, 0);
    endtask
    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        model_clear();
        e_valid = 0; e_hit = 0; e_idx = 0; e_state = 0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare();                     // reset state of the result
        rst_n = 1'b1;
        look(32'h0); look(32'h1234);   // R1: miss reports entry 0
        cur_req = "R5";
        look(32'h0); idle();           // R5: cleared zero tags do not match
        cur_req = "R8";
        wr(3, 32'hA000_0003, 5); look(32'hA000_0003); look(32'h5555);
        cur_req = "R4";
        for (int i = 0; i < N; i++) wr(i, 32'hB000_0000 + i, i);
        look(32'hFFFF_FFFF); look(32'hFFFF_FFFE);
        cur_req = "R7";
        look(32'hB000_0000); look(32'h1); look(32'hB000_0001); look(32'h1);
        cur_req = "R6";
        wr(9, 32'hC0DE, 2); wr(4, 32'hC0DE, 7); look(32'hC0DE); look(32'h1);
        cur_req = "R9";
        step(0, 0, 0, 0, 0, 0, 1, 4, 11, 0); look(32'hC0DE); look(32'h1);
        cur_req = "R10";
        step(1, 32'hB000_0005, 1, 5, 32'hD00D, 3, 0, 0, 0, 0);
        look(32'hB000_0005); look(32'hD00D);
        step(1, 32'hB000_0006, 1, 2, 32'hE1, 1, 0, 0, 0, 0);
        look(32'h1); look(32'hE1);
        cur_req = "R12";
        step(0, 0, 1, 7, 32'hF7, 9, 1, 7, 14, 0); look(32'hF7);
        cur_req = "R11";
        step(1, 32'hF7, 1, 8, 32'hF8, 6, 1, 7, 1, 1);
        look(32'hF7); look(32'hF8); look(32'h0);
        cur_req = "R2";
        idle(); idle(); look(32'h9); idle();
        cur_req = "R3";
        for (int c = 0; c < 4000; c++) begin
            int r = $urandom_range(0, 99);
            step($urandom_range(0, 1) == 1, 32'hDE00 + $urandom_range(0, 7),
                 r < 35, $urandom_range(0, N - 1), 32'hDE00 + $urandom_range(0, 7), $urandom_range(0, 15),
                 r % 5 == 0, $urandom_range(0, N - 1), $urandom_range(0, 15),
                 $urandom_range(0, 199) == 0);
        end
        idle(); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule